// File: doc/BRIEF.md
# Prescaled Interval Timer

A word-addressed countdown timer that sits next to a processor core. Software programs a start count, a reload period and a prescale value. It then sets a power bit and a run bit in the control word. While both bits are set, the count drops by one every (scale + 1) clock cycles.

When the count reaches zero, the block does two things: it latches a sticky expiry flag in the control word, and it raises an interrupt request for one cycle. What happens next depends on the reload bit:
- With reload set, the count is refilled from the period register and counting goes on.
- With reload clear, the count stays at zero.

The register port is a plain synchronous select/write-enable interface with no back-pressure. A write completes in the cycle it is selected. A read returns its data on the cycle after the select, and the read data holds until the next read.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset, all four registers read 0 and the interrupt output is low.
- R2: The register offsets are: control at 0x0, period at 0x4, scale at 0x8 and count at 0xC. Period and count read back the value written while the run bit is 0. Scale keeps only its low 8 bits, so a write of 0x128 reads back as 0x28. Read data appears on the cycle after a read select.
- R3: The control word bits are: bit 0 power, bit 1 run, bit 2 reload, bit 3 expiry flag. The count changes only when power and run are both 1. With run set and power clear, the count holds and no interrupt is raised.
- R4: The prescaler restarts each time counting becomes active. The count decrements once every (scale + 1) cycles. For a start count C, the interrupt is high in the cycle that follows C*(scale+1) clock edges after the enabling write.
- R5: With reload clear, expiry leaves the count at 0 and the count stays there. Exactly one interrupt is raised, and the control word reads 0xB.
- R6: With reload set, expiry refills the count from the period. The interrupt repeats every period*(scale+1) cycles, and the control word reads 0xF.
- R7: The interrupt output is high for exactly one cycle per expiry. Whenever it is high, the expiry flag is set.
- R8: The expiry flag is sticky. It is cleared by a control write with bit 3 = 1, or by a control write with bit 0 = 0. If an expiry happens in the same cycle as such a write, the flag stays set.
- R9: Writes to the count register while the run bit is 1 are ignored.
- R10: Writing 0 to the control word stops the timer, and the timer can be reprogrammed and run again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read select |
| irq_pulse | output | 1 | One-cycle interrupt request on expiry |

## Verification
The counting path is run with several combinations of count, scale and reload, and the cycle of every interrupt is predicted from the formulas above:
- A one-shot run with scale 1 separates per-cycle counting from prescaled counting.
- A large scale value, whose bits above bit 7 must be dropped, exposes a prescaler of the wrong width.
- A reload run checks that the spacing between interrupts follows the period and not the start count.

A run-without-power pattern checks that an enable bit alone does nothing. A clearing control write timed onto an expiry edge checks that a new expiry wins over the clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_DATA_W  = 32;
  localparam int TMR_ADDR_W  = 4;
  localparam int TMR_SCALE_W = 8;

  localparam logic [TMR_ADDR_W-1:0] OFS_CTRL   = 4'h0;
  localparam logic [TMR_ADDR_W-1:0] OFS_PERIOD = 4'h4;
  localparam logic [TMR_ADDR_W-1:0] OFS_SCALE  = 4'h8;
  localparam logic [TMR_ADDR_W-1:0] OFS_COUNT  = 4'hC;

  localparam int CB_PWR    = 0;
  localparam int CB_RUN    = 1;
  localparam int CB_RELOAD = 2;
  localparam int CB_FLAG   = 3;

  typedef struct packed {
    logic flag;
    logic reload;
    logic run;
    logic pwr;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  logic [SCALE_W-1:0] phase_q;

  assign tick = active && (phase_q == scale);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!active || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_downcounter.sv
module tmr_downcounter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             reload_en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;

  assign count  = count_q;
  assign expire = tick && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load_en) begin
      count_q <= load_val;
    end else if (tick && (count_q != '0)) begin
      if (expire) begin
        count_q <= reload_en ? period : '0;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W  = TMR_DATA_W,
  parameter int ADDR_W  = TMR_ADDR_W,
  parameter int SCALE_W = TMR_SCALE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t              ctrl_q;
  logic [DATA_W-1:0]  period_q;
  logic [SCALE_W-1:0] scale_q;
  logic [DATA_W-1:0]  count_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               irq_q;

  logic wr_ctrl, wr_period, wr_scale, wr_count, rd_en;
  logic active, tick, expire, flag_clr;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl   = bus_sel && bus_we && (bus_addr == OFS_CTRL);
  assign wr_period = bus_sel && bus_we && (bus_addr == OFS_PERIOD);
  assign wr_scale  = bus_sel && bus_we && (bus_addr == OFS_SCALE);
  assign wr_count  = bus_sel && bus_we && (bus_addr == OFS_COUNT);
  assign rd_en     = bus_sel && !bus_we;

  assign active   = ctrl_q.pwr && ctrl_q.run;
  assign flag_clr = wr_ctrl && (bus_wdata[CB_FLAG] || !bus_wdata[CB_PWR]);

  tmr_prescaler #(.SCALE_W(SCALE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .scale  (scale_q),
    .tick   (tick)
  );

  tmr_downcounter #(.CNT_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (wr_count && !ctrl_q.run),
    .load_val  (bus_wdata),
    .tick      (tick),
    .reload_en (ctrl_q.reload),
    .period    (period_q),
    .count     (count_q),
    .expire    (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      scale_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= expire;
      if (wr_ctrl) begin
        ctrl_q.pwr    <= bus_wdata[CB_PWR];
        ctrl_q.run    <= bus_wdata[CB_RUN];
        ctrl_q.reload <= bus_wdata[CB_RELOAD];
      end
      if (expire) begin
        ctrl_q.flag <= 1'b1;
      end else if (flag_clr) begin
        ctrl_q.flag <= 1'b0;
      end
      if (wr_period) period_q <= bus_wdata;
      if (wr_scale)  scale_q  <= bus_wdata[SCALE_W-1:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:   rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      OFS_PERIOD: rd_mux = period_q;
      OFS_SCALE:  rd_mux = {{(DATA_W-SCALE_W){1'b0}}, scale_q};
      OFS_COUNT:  rd_mux = count_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_pulse = irq_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int DATA_W = TMR_DATA_W,
  parameter int ADDR_W = TMR_ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_pulse,
  input ctrl_t             ctrl_q,
  input logic [DATA_W-1:0] count_q
);
  logic cnt_wr, ctl_wr, act;
  assign cnt_wr = bus_sel && bus_we && (bus_addr == OFS_COUNT);
  assign ctl_wr = bus_sel && bus_we && (bus_addr == OFS_CTRL);
  assign act    = ctrl_q.pwr && ctrl_q.run;

  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ctrl_q.flag); // R7

  AST_IRQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(act)); // R3

  AST_IDLE_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !cnt_wr) |=> $stable(count_q)); // R3

  AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && !ctrl_q.pwr && cnt_wr) |=> $stable(count_q)); // R9

  AST_ONESHOT_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !ctrl_q.reload && count_q == '0 && !ctl_wr) |=> (count_q == '0)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.flag && !ctl_wr) |=> ctrl_q.flag); // R8
endmodule

bind tick_interval_timer tmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .irq_pulse (irq_pulse),
  .ctrl_q    (ctrl_q),
  .count_q   (count_q)
);

// File: tb/tick_interval_timer_tb.sv
`timescale 1ns/1ps
module tick_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  logic done = 1'b0;

  localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_SCL = 4'h8, A_CNT = 4'hC;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver side: start the timer and push predicted interrupt cycles
  task automatic start_run(input logic [31:0] ctl, input int cnt, input int scl,
                           input int per, input int n_irq, output int base);
    wr(A_CTRL, ctl);
    @(negedge clk);
    base = cyc;
    for (int k = 0; k < n_irq; k++)
      exp_q.push_back(base + cnt*(scl+1) + k*per*(scl+1));
  endtask

  // Monitor: each interrupt cycle must match the next predicted one (R4, R7)
  always @(negedge clk) begin
    if (rst_n && irq_pulse) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual unexpected irq at cycle %0d expected none", cyc);
      end else begin
        check("R4 irq cycle", cyc, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    check("R1 irq", irq_pulse, 0);
    rd_check("R1 ctrl", A_CTRL, 0);
    rd_check("R1 period", A_PER, 0);
    rd_check("R1 scale", A_SCL, 0);
    rd_check("R1 count", A_CNT, 0);

    // R2 readback, R5 one-shot with scale 1
    wr(A_CTRL, 32'h1);
    wr(A_PER, 32'h10);
    wr(A_CNT, 32'h2);
    wr(A_SCL, 32'h1);
    rd_check("R2 period", A_PER, 32'h10);
    rd_check("R2 count", A_CNT, 32'h2);
    start_run(32'h3, 2, 1, 16, 1, base);
    wait_cyc(20);
    rd_check("R5 count zero", A_CNT, 0);
    rd_check("R5 ctrl 0xB", A_CTRL, 32'hB);
    check("R5 single irq", exp_q.size(), 0);
    // R9 count write while running ignored
    wr(A_CNT, 32'h5);
    rd_check("R9 count", A_CNT, 0);
    // R8 clear flag by writing bit 3
    wr(A_CTRL, 32'hB);
    rd_check("R8 flag cleared", A_CTRL, 32'h3);
    // R10 stop
    wr(A_CTRL, 32'h0);
    rd_check("R10 ctrl off", A_CTRL, 0);

    // R3 run without power: nothing moves
    wr(A_CNT, 32'h2);
    wr(A_SCL, 32'h0);
    wr(A_CTRL, 32'h2);
    wait_cyc(20);
    rd_check("R3 count held", A_CNT, 32'h2);
    wr(A_CTRL, 32'h0);

    // R4/R10 reprogram with wide scale write
    wr(A_CTRL, 32'h1);
    wr(A_CNT, 32'h3);
    wr(A_SCL, 32'h128);
    rd_check("R2 scale low byte", A_SCL, 32'h28);
    start_run(32'h3, 3, 40, 16, 1, base);
    wait_cyc(130);
    rd_check("R10 rerun count", A_CNT, 0);
    wr(A_CTRL, 32'h0);

    // R6 auto-reload
    wr(A_CTRL, 32'h1);
    wr(A_PER, 32'h4);
    wr(A_CNT, 32'h2);
    wr(A_SCL, 32'h3);
    start_run(32'h7, 2, 3, 4, 4, base);
    while (cyc < base + 58) @(negedge clk);
    rd_check("R6 ctrl 0xF", A_CTRL, 32'hF);
    wr(A_CTRL, 32'h0);
    rd_check("R8 power-off clears flag", A_CTRL, 0);
    check("R6 all reloads seen", exp_q.size(), 0);

    // R8 expiry wins over a clearing write on the same edge
    wr(A_CTRL, 32'h1);
    wr(A_PER, 32'h5);
    wr(A_CNT, 32'h1);
    wr(A_SCL, 32'h0);
    start_run(32'h7, 1, 0, 5, 2, base);
    while (cyc < base + 4) @(negedge clk);
    wr(A_CTRL, 32'hF);
    rd_check("R8 collision keeps flag", A_CTRL, 32'hF);
    wr(A_CTRL, 32'h0);
    wait_cyc(10);
    check("R7 collision irqs", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule